// File: doc/BRIEF.md
# Infrared NEC Frame Transmitter

This block turns a request into a complete pulse-distance infrared remote-control frame on one output pin. That pin already carries the 38 kHz carrier, so it can drive the base of an LED transistor stage directly. When a start strobe arrives while the block is idle, it captures an 8-bit address and an 8-bit command. It then plays out a long leader burst and a leader gap. Next come 32 data bits: the address, its bitwise inverse, the command and its inverse, each byte least significant bit first. A short closing burst ends the frame. A separate repeat strobe sends a short "key still held" frame instead, with the same leader burst, a shorter gap and the closing burst.

Every duration comes from the system clock frequency parameter `CLK_HZ`. Each one is a cycle count rounded to the nearest cycle: round(`CLK_HZ` × t). The carrier half period is round(`CLK_HZ` / 76000) cycles, with a minimum of one cycle. A busy flag covers the whole transmission. Requests that arrive while the flag is high are dropped.

Top module: `ir_nec_tx`

## Requirements
- R1: After reset, and in every cycle in which `busy_o` is low, `busy_o` and `ir_o` are both 0.
- R2: A strobe on `start_i` while idle makes `busy_o` high from the next cycle, which is burst cycle 0. A leader burst of round(9 ms) cycles follows, then a leader gap of round(4.5 ms) cycles with `ir_o` low.
- R3: After the leader gap, 32 bits are sent in this order: `addr_i` bits 0 to 7, inverted `addr_i` bits 0 to 7, `cmd_i` bits 0 to 7, inverted `cmd_i` bits 0 to 7. The values used are those sampled with the accepted strobe.
- R4: Each data bit is a burst of round(560 µs) cycles. For a 0 the burst is followed by a gap of round(560 µs) cycles, and for a 1 by a gap of round(1.68 ms) cycles.
- R5: A closing burst of round(560 µs) cycles follows the last bit gap. `busy_o` falls in the cycle after it ends, and the total busy time equals the sum of all segment lengths.
- R6: A strobe on `repeat_i` while idle (with `start_i` low) sends a leader burst of round(9 ms) cycles, a gap of round(2.25 ms) cycles and a closing burst of round(560 µs) cycles, with no data bits.
- R7: During bursts, `ir_o` follows a carrier with half period H = max(1, round(`CLK_HZ`/76000)) cycles. In busy cycle k (k = 0 in the first busy cycle) the carrier is 1 when floor(k/H) is even. The phase runs on through gaps. `ir_o` is 0 during every gap.
- R8: Strobes on `start_i` or `repeat_i` while `busy_o` is high are ignored. The frame in progress and its data do not change.
- R9: When `start_i` and `repeat_i` are both high in an idle cycle, a full data frame is sent.
- R10: All durations are computed from `CLK_HZ` as round(`CLK_HZ` × t), with a minimum of one cycle.
- R11: A strobe in the first idle cycle after a frame ends is accepted, and the new frame starts again at carrier phase k = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a full data frame (one-cycle strobe) |
| repeat_i | input | 1 | Request a repeat frame (one-cycle strobe) |
| addr_i | input | 8 | Address byte, sampled with an accepted strobe |
| cmd_i | input | 8 | Command byte, sampled with an accepted strobe |
| busy_o | output | 1 | High from the cycle after acceptance until the closing burst ends |
| ir_o | output | 1 | Carrier-modulated infrared drive |

## Verification
The hardest conditions to reach from the ports involve timing. One is a request that lands in the middle of a long frame, in either a burst or a gap. Another is a start and a repeat strobe in the same idle cycle. A third is a new strobe in the single idle cycle between two frames. The stimulus raises both strobes, with different data, at a chosen cycle inside a frame, then compares the whole frame cycle by cycle against a model built from the requirements. It also raises both strobes together from idle, and issues the next start in the first idle cycle after each frame. Address and command bytes come from a fixed-seed random source as well as from all-zero and all-one corner values.

// File: rtl/ir_nec_tx_pkg.sv
package ir_nec_tx_pkg;

    // Segment of the transmitted envelope
    typedef enum logic [2:0] {
        SEG_IDLE  = 3'd0,
        SEG_LEAD  = 3'd1,
        SEG_GAP   = 3'd2,
        SEG_MARK  = 3'd3,
        SEG_SPACE = 3'd4,
        SEG_TAIL  = 3'd5
    } seg_e;

    // Nominal durations in microseconds
    localparam int unsigned LEAD_US      = 9000;
    localparam int unsigned LEAD_GAP_US  = 4500;
    localparam int unsigned REP_GAP_US   = 2250;
    localparam int unsigned MARK_US      = 560;
    localparam int unsigned ZERO_GAP_US  = 560;
    localparam int unsigned ONE_GAP_US   = 1680;
    localparam int unsigned CARRIER_HZ   = 38000;
    localparam int unsigned PAYLOAD_BITS = 32;

    // Captured request
    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] addr;
    } nec_req_t;

    // Duration in microseconds to clock cycles, rounded, at least one
    function automatic int unsigned us_to_cycles(input longint unsigned clk_hz,
                                                 input longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us + 64'd500000) / 64'd1000000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    // Carrier half period in clock cycles, rounded, at least one
    function automatic int unsigned carrier_half(input longint unsigned clk_hz,
                                                 input longint unsigned car_hz);
        longint unsigned c;
        c = (clk_hz + car_hz) / (2 * car_hz);
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    // Payload word, sent from bit 0 upward
    function automatic logic [PAYLOAD_BITS-1:0] build_payload(input nec_req_t r);
        return {~r.cmd, r.cmd, ~r.addr, r.addr};
    endfunction

endpackage

// File: rtl/ir_nec_seg_timer.sv
module ir_nec_seg_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R10: a loaded segment length counts down one per cycle
    a_r10_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R10: an expired timer stays expired until reloaded
    a_r10_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/ir_nec_carrier.sv
module ir_nec_carrier #(
    parameter int unsigned HALF = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic carrier
);

    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;
    logic          car_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            car_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            car_q <= ~car_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign carrier = car_q;

    // R7: the carrier flips at the end of each half period
    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q == LAST) |=> (car_q != $past(car_q)));

    // R7: the carrier holds within a half period
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (run && cnt_q != LAST) |=> $stable(car_q));

    // R11: while stopped the carrier rests at phase zero
    a_r11_rest_phase: assert property (@(posedge clk) disable iff (rst)
        !run |=> (car_q && cnt_q == '0));

endmodule

// File: rtl/ir_nec_env_seq.sv
module ir_nec_env_seq
    import ir_nec_tx_pkg::*;
#(
    parameter int unsigned W        = 16,
    parameter int unsigned LEAD_C   = 1800,
    parameter int unsigned GAP_C    = 900,
    parameter int unsigned REP_C    = 450,
    parameter int unsigned MARK_C   = 112,
    parameter int unsigned ZERO_C   = 112,
    parameter int unsigned ONE_C    = 336
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         rep_req,
    input  logic [7:0]   addr,
    input  logic [7:0]   cmd,
    input  logic         seg_last,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         busy,
    output logic         env_on
);

    localparam int unsigned BW = $clog2(PAYLOAD_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(PAYLOAD_BITS - 1);

    localparam logic [W-1:0] LEAD_V = W'(LEAD_C - 1);
    localparam logic [W-1:0] GAP_V  = W'(GAP_C - 1);
    localparam logic [W-1:0] REP_V  = W'(REP_C - 1);
    localparam logic [W-1:0] MARK_V = W'(MARK_C - 1);
    localparam logic [W-1:0] ZERO_V = W'(ZERO_C - 1);
    localparam logic [W-1:0] ONE_V  = W'(ONE_C - 1);

    seg_e                    seg_q, seg_d;
    logic                    rep_q, rep_d;
    logic [PAYLOAD_BITS-1:0] pay_q, pay_d;
    logic [BW-1:0]           bit_q, bit_d;
    logic                    accept;
    nec_req_t                req;

    assign req    = '{cmd: cmd, addr: addr};
    assign accept = (seg_q == SEG_IDLE) && (start || rep_req);

    always_comb begin
        seg_d    = seg_q;
        rep_d    = rep_q;
        pay_d    = pay_q;
        bit_d    = bit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            seg_d    = SEG_LEAD;
            rep_d    = !start;
            pay_d    = build_payload(req);
            bit_d    = '0;
            tmr_load = 1'b1;
            tmr_val  = LEAD_V;
        end else if (seg_q != SEG_IDLE && seg_last) begin
            unique case (seg_q)
                SEG_LEAD: begin
                    seg_d    = SEG_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = rep_q ? REP_V : GAP_V;
                end
                SEG_GAP: begin
                    seg_d    = rep_q ? SEG_TAIL : SEG_MARK;
                    tmr_load = 1'b1;
                    tmr_val  = MARK_V;
                end
                SEG_MARK: begin
                    seg_d    = SEG_SPACE;
                    tmr_load = 1'b1;
                    tmr_val  = pay_q[0] ? ONE_V : ZERO_V;
                end
                SEG_SPACE: begin
                    seg_d    = (bit_q == LAST_BIT) ? SEG_TAIL : SEG_MARK;
                    pay_d    = pay_q >> 1;
                    bit_d    = bit_q + 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = MARK_V;
                end
                SEG_TAIL: begin
                    seg_d = SEG_IDLE;
                end
                default: begin
                    seg_d = SEG_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= SEG_IDLE;
            rep_q <= 1'b0;
            pay_q <= '0;
            bit_q <= '0;
        end else begin
            seg_q <= seg_d;
            rep_q <= rep_d;
            pay_q <= pay_d;
            bit_q <= bit_d;
        end
    end

    assign busy   = (seg_q != SEG_IDLE);
    assign env_on = (seg_q == SEG_LEAD) || (seg_q == SEG_MARK) || (seg_q == SEG_TAIL);

    // R2: an accepted strobe opens the leader burst next cycle
    a_r2_open_lead: assert property (@(posedge clk) disable iff (rst)
        (seg_q == SEG_IDLE && start) |=> (seg_q == SEG_LEAD && !rep_q));

    // R8: while a segment runs, state and data are frozen regardless of strobes
    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (seg_q != SEG_IDLE && !seg_last) |=> ($stable(seg_q) && $stable(pay_q) && $stable(rep_q)));

    // R9: start takes priority over repeat
    a_r9_start_wins: assert property (@(posedge clk) disable iff (rst)
        (seg_q == SEG_IDLE && start && rep_req) |=> !rep_q);

    // R6: a repeat frame never enters the data bits
    a_r6_no_bits: assert property (@(posedge clk) disable iff (rst)
        rep_q |-> (seg_q != SEG_MARK && seg_q != SEG_SPACE));

endmodule

// File: rtl/ir_nec_tx.sv
module ir_nec_tx
    import ir_nec_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       repeat_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] cmd_i,
    output logic       busy_o,
    output logic       ir_o
);

    localparam int unsigned LEAD_C = us_to_cycles(CLK_HZ, LEAD_US);
    localparam int unsigned GAP_C  = us_to_cycles(CLK_HZ, LEAD_GAP_US);
    localparam int unsigned REP_C  = us_to_cycles(CLK_HZ, REP_GAP_US);
    localparam int unsigned MARK_C = us_to_cycles(CLK_HZ, MARK_US);
    localparam int unsigned ZERO_C = us_to_cycles(CLK_HZ, ZERO_GAP_US);
    localparam int unsigned ONE_C  = us_to_cycles(CLK_HZ, ONE_GAP_US);
    localparam int unsigned HALF_C = carrier_half(CLK_HZ, CARRIER_HZ);
    localparam int unsigned TW     = $clog2(LEAD_C + 1);

    logic          seg_last;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          busy;
    logic          env_on;
    logic          carrier;

    ir_nec_seg_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (seg_last)
    );

    ir_nec_env_seq #(
        .W      (TW),
        .LEAD_C (LEAD_C),
        .GAP_C  (GAP_C),
        .REP_C  (REP_C),
        .MARK_C (MARK_C),
        .ZERO_C (ZERO_C),
        .ONE_C  (ONE_C)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .rep_req  (repeat_i),
        .addr     (addr_i),
        .cmd      (cmd_i),
        .seg_last (seg_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .busy     (busy),
        .env_on   (env_on)
    );

    ir_nec_carrier #(.HALF(HALF_C)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .carrier (carrier)
    );

    assign busy_o = busy;
    assign ir_o   = env_on & carrier;

    // R1: no light while idle
    a_r1_idle_dark: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !ir_o);

    // R5: once the closing burst is done the block returns idle and stays idle without a strobe
    a_r5_stay_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i && !repeat_i) |=> !busy_o);

endmodule

// File: tb/ir_nec_tx_tb_top.sv
`timescale 1ns/1ps
module ir_nec_tx_tb_top;

    localparam int CLK_HZ = 200_000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       repeat_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic [7:0] cmd_i = 8'h00;
    logic       busy_o;
    logic       ir_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ir_nec_tx #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .repeat_i (repeat_i),
        .addr_i   (addr_i),
        .cmd_i    (cmd_i),
        .busy_o   (busy_o),
        .ir_o     (ir_o)
    );

    // Durations from the requirements (R10)
    function automatic int cyc(input longint us);
        longint c;
        c = (longint'(CLK_HZ) * us + 500000) / 1000000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int half_p();
        int h;
        h = (CLK_HZ + 38000) / 76000;
        if (h < 1) h = 1;
        return h;
    endfunction

    function automatic logic car(input int k);
        return ((k / half_p()) % 2) == 0;
    endfunction

    function automatic int frame_len(input logic [7:0] a, input logic [7:0] c, input logic rep);
        logic [31:0] pl;
        int t;
        pl = {~c, c, ~a, a};
        t = cyc(9000) + (rep ? cyc(2250) : cyc(4500));
        if (!rep) begin
            for (int i = 0; i < 32; i++) t += cyc(560) + (pl[i] ? cyc(1680) : cyc(560));
        end
        t += cyc(560);
        return t;
    endfunction

    // Returns {busy, ir} expected in busy cycle k
    function automatic logic [1:0] model(input int k, input logic [7:0] a,
                                         input logic [7:0] c, input logic rep);
        logic [31:0] pl;
        int pos;
        int sp;
        pl = {~c, c, ~a, a};
        if (k < cyc(9000)) return {1'b1, car(k)};
        pos = cyc(9000);
        sp = rep ? cyc(2250) : cyc(4500);
        if (k < pos + sp) return 2'b10;
        pos += sp;
        if (!rep) begin
            for (int i = 0; i < 32; i++) begin
                if (k < pos + cyc(560)) return {1'b1, car(k)};
                pos += cyc(560);
                sp = pl[i] ? cyc(1680) : cyc(560);
                if (k < pos + sp) return 2'b10;
                pos += sp;
            end
        end
        if (k < pos + cyc(560)) return {1'b1, car(k)};
        return 2'b00;
    endfunction

    // Caller is at a negedge. Drives the strobes, then checks the frame cycle by cycle,
    // finishing at the negedge of the first idle cycle.
    task automatic run_frame(input logic [7:0] a, input logic [7:0] c,
                             input logic drv_start, input logic drv_rep,
                             input int inject_k, input string tag);
        logic rep;
        int total;
        int bad_busy;
        int bad_ir;
        logic [1:0] exp;
        rep = !drv_start;
        total = frame_len(a, c, rep);
        addr_i = a;
        cmd_i = c;
        start_i = drv_start;
        repeat_i = drv_rep;
        @(negedge clk);
        bad_busy = 0;
        bad_ir = 0;
        for (int k = 0; k <= total; k++) begin
            start_i = 1'b0;
            repeat_i = 1'b0;
            exp = model(k, a, c, rep);
            if (busy_o !== exp[1]) begin
                if (bad_busy == 0)
                    $display("FAIL %s busy_o cycle %0d actual=%0b expected=%0b", tag, k, busy_o, exp[1]);
                bad_busy++;
            end
            if (ir_o !== exp[0]) begin
                if (bad_ir == 0)
                    $display("FAIL %s ir_o cycle %0d actual=%0b expected=%0b", tag, k, ir_o, exp[0]);
                bad_ir++;
            end
            if (k == inject_k) begin
                start_i = 1'b1;
                repeat_i = 1'b1;
                addr_i = ~a;
                cmd_i = c ^ 8'h5A;
            end
            if (k < total) @(negedge clk);
        end
        checks += 2;
        if (bad_busy != 0) errors++;
        if (bad_ir != 0) errors++;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        checks++;
        if (busy_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 busy_o after reset actual=%0b expected=0", busy_o);
        end
        checks++;
        if (ir_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 ir_o after reset actual=%0b expected=0", ir_o);
        end
        for (int i = 0; i < 20; i++) @(negedge clk);
        checks++;
        if (busy_o !== 1'b0 || ir_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle outputs actual=%0b%0b expected=00", busy_o, ir_o);
        end

        // R2 R3 R4 R5 R7 R10: all-zero address, all-one command
        run_frame(8'h00, 8'hFF, 1'b1, 1'b0, -1, "R2_R3_R4_R5_R7_R10 frame zero-addr");
        // R11: back-to-back start in the first idle cycle; R8: strobes mid-gap are ignored
        run_frame(8'hA5, 8'h3C, 1'b1, 1'b0, 2000, "R11_R8 back-to-back with mid-gap strobe");
        // R8: strobes during a data burst are ignored
        run_frame(8'h81, 8'h7E, 1'b1, 1'b0, 2750, "R8 strobe during data burst");
        // R6: repeat frame, with a strobe inside its gap (R8)
        run_frame(8'h12, 8'h34, 1'b0, 1'b1, 1900, "R6_R8 repeat frame");
        // R9: both strobes together send a full frame
        run_frame(8'hC3, 8'h0F, 1'b1, 1'b1, -1, "R9 simultaneous strobes");
        // Random payloads
        for (int n = 0; n < 2; n++) begin
            logic [7:0] ra;
            logic [7:0] rc;
            ra = 8'($urandom);
            rc = 8'($urandom);
            run_frame(ra, rc, 1'b1, 1'b0, -1, "R3_R4_R7 random payload");
        end

        // R5/R1: remains idle afterwards
        for (int i = 0; i < 10; i++) @(negedge clk);
        checks++;
        if (busy_o !== 1'b0 || ir_o !== 1'b0) begin
            errors++;
            $display("FAIL R5 idle after frames actual=%0b%0b expected=00", busy_o, ir_o);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule